// File: doc/BRIEF.md
# Wait-Lock Handoff Arbiter

This block is the hardware side of a long-hold lock shared by several processors. Any processor may ask for the lock. If the lock is free, the requester becomes the owner at once. If the lock is held, the requester is recorded in a mask that has one bit per processor and goes on with other work. When the owner lets go of the lock, the arbiter does not wake every waiter to contend again. It chooses a single waiter, the lowest-numbered one, and gives the lock to it directly. In the same cycle it removes that waiter from the mask, records it as the new owner and sends a one-cycle interprocessor interrupt pulse to that processor alone.

The outputs are the current owner's index, a busy flag and one interrupt line per processor. The owner index is only meaningful while the busy flag is set. A release from a processor that does not own the lock, or a release while the lock is free, changes nothing except a one-cycle error pulse. All outputs are registered. Each output reflects, one clock after the edge, the requests sampled at that edge.

Top module: `wl_handoff_arb`

## Requirements
- R1: After reset `busy_o`=0, `owner_o`=0, `irq_o`=0, `rel_err_o`=0 and the waiting mask is empty.
- R2: An acquire on a free lock is granted at the next edge without any interrupt. Bit i of `acq_i` is processor i. If several processors request in the same cycle, the lowest index becomes the owner and the others are recorded as waiting.
- R3: An acquire from a non-owner while the lock is busy sets that processor's waiting bit. While the owner does not release, `owner_o` and `busy_o` stay unchanged.
- R4: A release by the owner while waiters exist gives the lock at the next edge to the lowest-numbered waiter. Acquires arriving in the release cycle count as waiters. `busy_o` stays 1, `owner_o` becomes that index, and `irq_o` carries only that processor's bit for that one cycle.
- R5: A release by the owner with no waiters, including same-cycle acquires, clears `busy_o` at the next edge, and `irq_o` stays 0.
- R6: At most one bit of `irq_o` is set in any cycle, and no bit stays set for two consecutive cycles.
- R7: A release by a non-owner, or any release while the lock is free, is ignored: ownership and the mask are not changed by it. `rel_err_o` is 1 for exactly the cycle after it.
- R8: A processor that is handed the lock is removed from the waiting mask. Each recorded wait produces exactly one handoff, and once every waiter has been served, the final release frees the lock.
- R9: An acquire from the current owner is ignored. A repeated acquire from a processor that is already waiting does not add a second handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | N_CPU | Per-processor acquire request, bit i = processor i |
| rel_i | input | N_CPU | Per-processor release request |
| owner_o | output | $clog2(N_CPU) | Index of the owner, valid while busy_o |
| busy_o | output | 1 | Lock is held |
| irq_o | output | N_CPU | One-cycle handoff interrupt, bit i = processor i |
| rel_err_o | output | 1 | One-cycle pulse after an invalid release |

## Verification
The hardest case to reach is a release by the owner in the same cycle as fresh acquires from other processors, stray releases from non-owners, and a redundant acquire by the owner itself. In that cycle the new requests must take part in choosing the next owner while the stray releases are only flagged. Directed steps build this cycle explicitly. The random phase makes the owner release about half the time and mixes in acquire and stray-release bits from $urandom with a fixed seed, so such collisions happen often. A bench model computes the expected owner, busy flag, interrupt vector and error pulse for every cycle.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned WL_DEF_CPUS = 4;

  typedef enum logic [1:0] {
    WL_EV_NONE    = 2'd0,
    WL_EV_GRANT   = 2'd1,
    WL_EV_HANDOFF = 2'd2,
    WL_EV_FREE    = 2'd3
  } wl_event_e;
endpackage

// File: rtl/wl_pick_first.sv
module wl_pick_first #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign gnt_o[g]    = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/wl_rel_check.sv
module wl_rel_check #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          busy_i,
  input  logic [IW-1:0] owner_i,
  input  logic [N-1:0]  rel_i,
  output logic [N-1:0]  own_oh_o,
  output logic          valid_rel_o,
  output logic          bad_rel_o
);
  always_comb begin
    own_oh_o = '0;
    if (busy_i) own_oh_o[owner_i] = 1'b1;
  end

  assign valid_rel_o = |(rel_i & own_oh_o);
  // any release bit outside the owner's own is stray
  assign bad_rel_o   = |(rel_i & ~own_oh_o);
endmodule

// File: rtl/wl_handoff_arb.sv
module wl_handoff_arb
  import wl_pkg::*;
#(
  parameter int unsigned N_CPU = WL_DEF_CPUS,
  localparam int unsigned IW   = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] acq_i,
  input  logic [N_CPU-1:0] rel_i,
  output logic [IW-1:0]    owner_o,
  output logic             busy_o,
  output logic [N_CPU-1:0] irq_o,
  output logic             rel_err_o
);
  logic             busy_q, busy_d;
  logic [IW-1:0]    owner_q, owner_d;
  logic [N_CPU-1:0] wait_q, wait_d;
  logic [N_CPU-1:0] irq_q, irq_d;
  logic             err_q;

  logic [N_CPU-1:0] own_oh, pool, gnt;
  logic [IW-1:0]    pick_idx;
  logic             pick_any, valid_rel, bad_rel;
  wl_event_e        ev;

  wl_rel_check #(.N(N_CPU)) u_rel (
    .busy_i     (busy_q),
    .owner_i    (owner_q),
    .rel_i      (rel_i),
    .own_oh_o   (own_oh),
    .valid_rel_o(valid_rel),
    .bad_rel_o  (bad_rel)
  );

  // wait mask is empty while free, so one picker serves grant and handoff
  assign pool = wait_q | (acq_i & ~own_oh);

  wl_pick_first #(.N(N_CPU)) u_pick (
    .req_i(pool),
    .gnt_o(gnt),
    .idx_o(pick_idx),
    .any_o(pick_any)
  );

  always_comb begin
    if (!busy_q)        ev = pick_any ? WL_EV_GRANT : WL_EV_NONE;
    else if (valid_rel) ev = pick_any ? WL_EV_HANDOFF : WL_EV_FREE;
    else                ev = WL_EV_NONE;
  end

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    wait_d  = pool;
    irq_d   = '0;
    unique case (ev)
      WL_EV_GRANT: begin
        busy_d  = 1'b1;
        owner_d = pick_idx;
        wait_d  = pool & ~gnt;
      end
      WL_EV_HANDOFF: begin
        owner_d = pick_idx;
        wait_d  = pool & ~gnt;
        irq_d   = gnt;
      end
      WL_EV_FREE: begin
        busy_d = 1'b0;
        wait_d = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      wait_q  <= '0;
      irq_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      wait_q  <= wait_d;
      irq_q   <= irq_d;
      err_q   <= bad_rel;
    end
  end

  assign owner_o   = owner_q;
  assign busy_o    = busy_q;
  assign irq_o     = irq_q;
  assign rel_err_o = err_q;

  assert_irq_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_q));

  assert_irq_no_repeat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != '0) |=> ((irq_q & $past(irq_q)) == '0));

  assert_irq_to_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != '0) |-> (busy_q && irq_q[owner_q]));

  assert_irq_after_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && valid_rel |=> busy_q == (($past(pool) != '0)));

  assert_owner_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !valid_rel |=> busy_q && owner_q == $past(owner_q) && irq_q == '0);

  assert_owner_not_waiting_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !wait_q[owner_q]);

  assert_free_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (wait_q == '0 && irq_q == '0));
endmodule

// File: tb/wl_handoff_arb_tb_top.sv
module wl_handoff_arb_tb_top;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] acq = '0;
  logic [3:0] rel = '0;
  logic [1:0] owner;
  logic       busy;
  logic [3:0] irq;
  logic       rel_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       m_busy = 1'b0;
  logic [1:0] m_owner = '0;
  logic [3:0] m_wait = '0;
  logic [3:0] m_irq = '0;
  logic       m_err = 1'b0;

  always #4 clk = ~clk;

  wl_handoff_arb #(.N_CPU(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .acq_i(acq), .rel_i(rel),
    .owner_o(owner), .busy_o(busy), .irq_o(irq), .rel_err_o(rel_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference behaviour written from the requirements
  task automatic model(input logic [3:0] a, input logic [3:0] r);
    logic [3:0] ohown, pool, pick;
    logic vrel;
    int idx;
    ohown = m_busy ? (4'b0001 << m_owner) : 4'b0000;
    vrel  = m_busy && r[m_owner];
    pool  = m_wait | (a & ~ohown);
    idx = -1;
    for (int i = 3; i >= 0; i--) if (pool[i]) idx = i;
    pick = (idx >= 0) ? (4'b0001 << idx) : 4'b0000;
    m_err = |(r & ~(vrel ? ohown : 4'b0000));
    m_irq = '0;
    if (!m_busy) begin
      if (idx >= 0) begin m_busy = 1'b1; m_owner = 2'(idx); end
      m_wait = pool & ~pick;
    end else if (vrel) begin
      if (idx >= 0) begin m_owner = 2'(idx); m_irq = pick; m_wait = pool & ~pick; end
      else begin m_busy = 1'b0; m_wait = '0; end
    end else begin
      m_wait = pool;
    end
  endtask

  task automatic step(input logic [3:0] a, input logic [3:0] r, input string tag);
    acq = a; rel = r;
    model(a, r);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " busy"}, busy, m_busy);
    chk({tag, " irq"}, irq, m_irq);
    chk({tag, " err"}, rel_err, m_err);
    if (m_busy) chk({tag, " owner"}, owner, m_owner);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 owner", owner, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", rel_err, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    step(4'b1010, 4'b0000, "R2 simultaneous grant");
    chk("R2 owner lowest", owner, 1);
    step(4'b0101, 4'b0000, "R3 queue while busy");
    chk("R3 owner unchanged", owner, 1);
    step(4'b0010, 4'b0000, "R9 owner reacquire");
    step(4'b0001, 4'b0000, "R9 repeat waiter");
    step(4'b0000, 4'b0010, "R4 handoff");
    chk("R4 owner lowest waiter", owner, 0);
    chk("R4 irq cpu0", irq, 1);
    step(4'b0000, 4'b1000, "R7 stray release");
    chk("R6 irq cleared", irq, 0);
    chk("R7 err pulse", rel_err, 1);
    chk("R7 owner kept", owner, 0);
    step(4'b0010, 4'b0001, "R4 release with same-cycle acquire");
    chk("R4 same-cycle acquire wins", owner, 1);
    chk("R7 err single cycle", rel_err, 0);
    step(4'b0000, 4'b0010, "R8 serve 2");
    chk("R8 owner 2", owner, 2);
    step(4'b0000, 4'b0100, "R8 serve 3");
    chk("R8 irq cpu3", irq, 8);
    step(4'b0000, 4'b1000, "R5 last release");
    chk("R5 freed", busy, 0);
    chk("R5 no irq", irq, 0);
    step(4'b0000, 4'b0100, "R7 release while free");
    chk("R7 still free", busy, 0);
    chk("R7 err when free", rel_err, 1);

    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] a, r;
      a = 4'($urandom) & 4'($urandom);
      r = '0;
      if (($urandom % 2) == 0 && m_busy) r[m_owner] = 1'b1;
      if (($urandom % 8) == 0) r = r | 4'($urandom);
      step(a, r, "R4 R6 random");
    end

    acq = '0; rel = '0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule